// File: doc/BRIEF.md
# Interrupt Trap Entry Sequencer

This unit carries out the whole architectural state change that happens when a hart takes an interrupt. A request carries the program counter of the next instruction that has not yet run, the privilege level the hart holds now, the full cause word with the interrupt flag in its top bit, a flag that picks supervisor or machine as the target level, the current status word and both trap-vector registers. In a single step the unit works out the handler address, the new privilege level and the four register writes that the target level needs: exception pc, cause, trap value and status.

Requests use a valid/ready handshake. A request is taken on any rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low while reset is asserted and on the first edge after reset is released. After that it stays high, so the unit never applies back-pressure and can take a new request on every cycle. Results are not held: each accepted request produces a one-cycle strobe in the next cycle. The strobe comes with the redirect pc and the write-enables and write data for the register file, which must use them in that same cycle.

Top module: `trap_entry_unit`

## Requirements
- R1: While reset is asserted, `req_ready`, `redir_valid`, every write-enable, `priv_out` and every data output read zero.
- R2: In the cycle after an accepted request, `redir_valid`, `epc_we`, `cause_we`, `tval_we` and `status_we` are all high together, for that one cycle only, unless another request was accepted on the next edge. They are low in every cycle that does not follow an acceptance.
- R3: `epc_wdata` equals the `req_pc` of the accepted request.
- R4: `cause_wdata` equals the accepted `req_cause` unchanged, including the interrupt flag in bit XLEN-1.
- R5: `tval_wdata` is zero whenever `tval_we` is high.
- R6: When the low two bits of the selected trap vector are 0, 2 or 3, the redirect pc is the trap vector with those two bits cleared. The selected vector is `stvec_in` when `req_to_s` is 1 and `mtvec_in` otherwise.
- R7: When the low two bits of the selected trap vector are 1, the redirect pc is the cleared base plus four times the cause with its top bit removed. For codes 1, 3, 5, 7, 9 and 11 this gives offsets of 4, 12, 20, 28, 36 and 44 bytes.
- R8: For a supervisor-target trap, status bit 5 takes the old value of bit 1, bit 1 is cleared, and bit 8 is set to 1 if the old privilege was supervisor (1) and to 0 if it was user (0). All other bits pass through unchanged.
- R9: For a machine-target trap, status bit 7 takes the old value of bit 3, bit 3 is cleared, and bits 12:11 receive the old privilege code (user 0, supervisor 1, machine 3). All other bits pass through unchanged.
- R10: `priv_out` becomes 1 for a supervisor target and 3 for a machine target, and `tgt_is_s` marks which level's registers the writes address.
- R11: Requests accepted on consecutive edges each yield their own strobe cycle, with no cycle lost and no payload mixed between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Trap request present |
| req_ready | output | 1 | Unit can accept a request |
| req_pc | input | XLEN | Pc of the next unexecuted instruction |
| req_mode | input | 2 | Privilege code before the trap |
| req_cause | input | XLEN | Cause word with interrupt flag |
| req_to_s | input | 1 | 1: supervisor target, 0: machine target |
| status_in | input | XLEN | Current status word |
| stvec_in | input | XLEN | Supervisor trap vector |
| mtvec_in | input | XLEN | Machine trap vector |
| redir_valid | output | 1 | Pc redirect strobe |
| redir_pc | output | XLEN | Handler address |
| priv_out | output | 2 | New privilege code |
| tgt_is_s | output | 1 | Writes address supervisor registers |
| epc_we | output | 1 | Exception-pc write enable |
| epc_wdata | output | XLEN | Exception-pc write data |
| cause_we | output | 1 | Cause write enable |
| cause_wdata | output | XLEN | Cause write data |
| tval_we | output | 1 | Trap-value write enable |
| tval_wdata | output | XLEN | Trap-value write data |
| status_we | output | 1 | Status write enable |
| status_wdata | output | XLEN | Stacked status word |

## Verification
The handler address and the status stacking for one request are settled in the same register stage while the next request is already being captured, so two traps can be in flight within one cycle. The bench provokes this by holding `req_valid` high over several edges. Each request in that run differs in target level, vector mode and status pattern. A behavioural model records every acceptance and checks each strobe cycle's pc, mode and status against the request taken on the previous edge. A mixed or dropped payload therefore appears as a field mismatch or as a strobe missing from the sequence.

// File: rtl/trap_entry_pkg.sv
`timescale 1ns/1ps
package trap_entry_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  // status bit positions the software handler decodes
  localparam int S_IE_BIT  = 1;
  localparam int M_IE_BIT  = 3;
  localparam int S_PIE_BIT = 5;
  localparam int M_PIE_BIT = 7;
  localparam int S_PP_BIT  = 8;
  localparam int M_PP_LO   = 11;
  localparam int M_PP_HI   = 12;

  localparam logic [1:0] TVEC_VECTORED = 2'd1;
endpackage

// File: rtl/trap_target_pc.sv
`timescale 1ns/1ps
module trap_target_pc
  import trap_entry_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] tvec,
  input  logic [XLEN-3:0] code,
  output logic [XLEN-1:0] target
);
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  assign base   = {tvec[XLEN-1:2], 2'b00};
  // cause number scaled by four; upper code bits fall off the word
  assign offset = {code, 2'b00};

  always_comb begin
    if (tvec[1:0] == TVEC_VECTORED) target = base + offset;
    else                            target = base;
  end
endmodule

// File: rtl/trap_status_stack.sv
`timescale 1ns/1ps
module trap_status_stack
  import trap_entry_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] status,
  input  logic [1:0]      prev_mode,
  input  logic            to_s,
  output logic [XLEN-1:0] stacked
);
  always_comb begin
    stacked = status;
    if (to_s) begin
      stacked[S_PIE_BIT] = status[S_IE_BIT];
      stacked[S_IE_BIT]  = 1'b0;
      stacked[S_PP_BIT]  = (prev_mode == 2'(PRIV_S));
    end else begin
      stacked[M_PIE_BIT]         = status[M_IE_BIT];
      stacked[M_IE_BIT]          = 1'b0;
      stacked[M_PP_HI:M_PP_LO]   = prev_mode;
    end
  end
endmodule

// File: rtl/trap_entry_unit.sv
`timescale 1ns/1ps
module trap_entry_unit
  import trap_entry_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [XLEN-1:0] req_pc,
  input  logic [1:0]      req_mode,
  input  logic [XLEN-1:0] req_cause,
  input  logic            req_to_s,
  input  logic [XLEN-1:0] status_in,
  input  logic [XLEN-1:0] stvec_in,
  input  logic [XLEN-1:0] mtvec_in,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_pc,
  output logic [1:0]      priv_out,
  output logic            tgt_is_s,
  output logic            epc_we,
  output logic [XLEN-1:0] epc_wdata,
  output logic            cause_we,
  output logic [XLEN-1:0] cause_wdata,
  output logic            tval_we,
  output logic [XLEN-1:0] tval_wdata,
  output logic            status_we,
  output logic [XLEN-1:0] status_wdata
);
  localparam int CODE_W = XLEN - 2;

  logic            ready_q;
  logic            accept;
  logic            strobe_q;
  logic [XLEN-1:0] sel_tvec;
  logic [XLEN-1:0] nxt_pc;
  logic [XLEN-1:0] nxt_status;
  logic [XLEN-1:0] pc_q, epc_q, cause_q, status_q;
  logic [1:0]      priv_q;
  logic            tgt_s_q;

  assign accept   = req_valid & ready_q;
  assign sel_tvec = req_to_s ? stvec_in : mtvec_in;

  trap_target_pc #(.XLEN(XLEN)) u_pc (
    .tvec   (sel_tvec),
    .code   (req_cause[CODE_W-1:0]),
    .target (nxt_pc)
  );

  trap_status_stack #(.XLEN(XLEN)) u_stack (
    .status    (status_in),
    .prev_mode (req_mode),
    .to_s      (req_to_s),
    .stacked   (nxt_status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q  <= 1'b0;
      strobe_q <= 1'b0;
      pc_q     <= '0;
      epc_q    <= '0;
      cause_q  <= '0;
      status_q <= '0;
      priv_q   <= 2'(PRIV_U);
      tgt_s_q  <= 1'b0;
    end else begin
      ready_q  <= 1'b1;
      strobe_q <= accept;
      if (accept) begin
        pc_q     <= nxt_pc;
        epc_q    <= req_pc;
        cause_q  <= req_cause;
        status_q <= nxt_status;
        priv_q   <= req_to_s ? 2'(PRIV_S) : 2'(PRIV_M);
        tgt_s_q  <= req_to_s;
      end
    end
  end

  assign req_ready    = ready_q;
  assign redir_valid  = strobe_q;
  assign redir_pc     = pc_q;
  assign priv_out     = priv_q;
  assign tgt_is_s     = tgt_s_q;
  assign epc_we       = strobe_q;
  assign epc_wdata    = epc_q;
  assign cause_we     = strobe_q;
  assign cause_wdata  = cause_q;
  assign tval_we      = strobe_q;
  assign tval_wdata   = '0;
  assign status_we    = strobe_q;
  assign status_wdata = status_q;
endmodule

// File: rtl/trap_entry_chk.sv
`timescale 1ns/1ps
module trap_entry_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [XLEN-1:0] req_pc,
  input logic [XLEN-1:0] req_cause,
  input logic            req_to_s,
  input logic            redir_valid,
  input logic [1:0]      priv_out,
  input logic            epc_we,
  input logic [XLEN-1:0] epc_wdata,
  input logic [XLEN-1:0] cause_wdata,
  input logic            tval_we,
  input logic [XLEN-1:0] tval_wdata,
  input logic            status_we,
  input logic            tgt_is_s,
  input logic [XLEN-1:0] status_wdata
);
  // R2: a strobe appears exactly when the previous edge accepted a request
  a_r2_strobe_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid == $past(req_valid && req_ready));

  // R3
  a_r3_epc_is_pc: assert property (@(posedge clk) disable iff (!rst_n)
    epc_we |-> epc_wdata == $past(req_pc));

  // R4
  a_r4_cause_copied: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> cause_wdata == $past(req_cause));

  // R5
  a_r5_tval_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tval_we |-> tval_wdata == '0);

  // R8
  a_r8_sie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (status_we && tgt_is_s) |-> !status_wdata[1]);

  // R9
  a_r9_mie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (status_we && !tgt_is_s) |-> !status_wdata[3]);

  // R10
  a_r10_priv_target: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> priv_out == ($past(req_to_s) ? 2'd1 : 2'd3));
endmodule

bind trap_entry_unit trap_entry_chk #(.XLEN(XLEN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_pc       (req_pc),
  .req_cause    (req_cause),
  .req_to_s     (req_to_s),
  .redir_valid  (redir_valid),
  .priv_out     (priv_out),
  .epc_we       (epc_we),
  .epc_wdata    (epc_wdata),
  .cause_wdata  (cause_wdata),
  .tval_we      (tval_we),
  .tval_wdata   (tval_wdata),
  .status_we    (status_we),
  .tgt_is_s     (tgt_is_s),
  .status_wdata (status_wdata)
);

// File: tb/trap_entry_unit_tb_top.sv
`timescale 1ns/1ps
module trap_entry_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_pc = '0;
  logic [1:0]  req_mode = '0;
  logic [63:0] req_cause = '0;
  logic        req_to_s = 1'b0;
  logic [63:0] status_in = '0, stvec_in = '0, mtvec_in = '0;
  logic        redir_valid, tgt_is_s, epc_we, cause_we, tval_we, status_we;
  logic [63:0] redir_pc, epc_wdata, cause_wdata, tval_wdata, status_wdata;
  logic [1:0]  priv_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trap_entry_unit #(.XLEN(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_pc(req_pc), .req_mode(req_mode), .req_cause(req_cause), .req_to_s(req_to_s),
    .status_in(status_in), .stvec_in(stvec_in), .mtvec_in(mtvec_in),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .priv_out(priv_out),
    .tgt_is_s(tgt_is_s), .epc_we(epc_we), .epc_wdata(epc_wdata),
    .cause_we(cause_we), .cause_wdata(cause_wdata), .tval_we(tval_we),
    .tval_wdata(tval_wdata), .status_we(status_we), .status_wdata(status_wdata)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference
  function automatic logic [63:0] ref_pc(input logic [63:0] tv, input logic [63:0] c);
    logic [63:0] num = c & ~(64'h1 << 63);
    if (tv % 4 == 1) return (tv - 64'd1) + num * 64'd4;
    return tv - (tv % 4);
  endfunction

  function automatic logic [63:0] ref_status(input logic [63:0] st, input logic [1:0] m,
                                             input logic s);
    logic [63:0] r = st;
    if (s) begin
      r[5] = st[1]; r[1] = 1'b0; r[8] = (m == 2'd1);
    end else begin
      r[7] = st[3]; r[3] = 1'b0; r[12:11] = m;
    end
    return r;
  endfunction

  logic        exp_v = 1'b0;
  logic        exp_ready = 1'b0;
  logic [63:0] e_pc, e_epc, e_cause, e_status;
  logic [1:0]  e_priv;
  logic        e_s, e_vec;
  int          strobes = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_v <= 1'b0; exp_ready <= 1'b0;
    end else begin
      exp_ready <= 1'b1;
      exp_v <= req_valid && exp_ready;
      if (req_valid && exp_ready) begin
        e_pc     <= ref_pc(req_to_s ? stvec_in : mtvec_in, req_cause);
        e_vec    <= ((req_to_s ? stvec_in : mtvec_in) % 4 == 1);
        e_epc    <= req_pc;
        e_cause  <= req_cause;
        e_status <= ref_status(status_in, req_mode, req_to_s);
        e_priv   <= req_to_s ? 2'd1 : 2'd3;
        e_s      <= req_to_s;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1 ready", 64'(req_ready), 0);
      chk("R1 strobe", 64'(redir_valid), 0);
      chk("R1 we", 64'({epc_we, cause_we, tval_we, status_we}), 0);
      chk("R1 data", redir_pc | epc_wdata | cause_wdata | status_wdata | 64'(priv_out), 0);
    end else if (!done) begin
      chk("R2 ready", 64'(req_ready), 64'(exp_ready));
      chk("R2 strobe", 64'(redir_valid), 64'(exp_v));
      chk("R2 write enables", 64'({epc_we, cause_we, tval_we, status_we}), exp_v ? 64'hF : 0);
      if (exp_v) begin
        strobes++;
        chk("R3 epc", epc_wdata, e_epc);
        chk("R4 cause", cause_wdata, e_cause);
        chk("R5 tval", tval_wdata, 0);
        chk(e_vec ? "R7 vectored pc" : "R6 direct pc", redir_pc, e_pc);
        chk(e_s ? "R8 sstatus stack" : "R9 mstatus stack", status_wdata, e_status);
        chk("R10 priv", 64'(priv_out), 64'(e_priv));
        chk("R10 target", 64'(tgt_is_s), 64'(e_s));
      end
    end
  end

  task automatic put(input logic [63:0] pc, input logic [1:0] m, input logic [63:0] c,
                     input logic s, input logic [63:0] st, input logic [63:0] stv,
                     input logic [63:0] mtv);
    req_valid = 1'b1; req_pc = pc; req_mode = m; req_cause = c; req_to_s = s;
    status_in = st; stvec_in = stv; mtvec_in = mtv;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    req_pc = 64'hDEAD_BEEF; status_in = '1;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  localparam logic [63:0] IRQ = 64'h1 << 63;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R6: direct machine trap from user, MIE set
    put(64'h1000, 2'd0, IRQ | 7, 1'b0, 64'h8, 64'h0, 64'h8000_0000);
    idle(1);
    // R7: vectored machine trap from supervisor, external code 11
    put(64'h2004, 2'd1, IRQ | 11, 1'b0, 64'h0, 64'h0, 64'h8000_1001);
    idle(2);
    // R7 R8: vectored supervisor trap from user, SIE set
    put(64'h3008, 2'd0, IRQ | 1, 1'b1, 64'h2, 64'h4000_0001, 64'h0);
    idle(1);
    // R8: supervisor from supervisor, SIE clear, SPIE set, other bits all ones
    put(64'h400C, 2'd1, IRQ | 9, 1'b1, ~64'h2, 64'h4000_0101, 64'h0);
    idle(1);
    // R6: tvec modes 2 and 3 treated as direct
    put(64'h5000, 2'd0, IRQ | 5, 1'b1, 64'h0, 64'h4000_0202, 64'h0);
    idle(1);
    put(64'h6000, 2'd3, IRQ | 3, 1'b0, ~64'h0, 64'h0, 64'h8000_0303);
    idle(1);
    // R11: back-to-back requests with mixed targets and modes
    put(64'h7000, 2'd3, IRQ | 11, 1'b0, 64'h88, 64'h0, 64'h9000_0001);
    put(64'h7004, 2'd0, IRQ | 9, 1'b1, 64'h22, 64'hA000_0000, 64'h0);
    put(64'h7008, 2'd1, IRQ | 7, 1'b0, 64'h1800, 64'h0, 64'h9000_0000);
    put(64'h700C, 2'd1, IRQ | 5, 1'b1, 64'h120, 64'hA000_0041, 64'h0);
    idle(3);
    chk("R11 strobe count", 64'(strobes), 64'd10);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule